// File: doc/BRIEF.md
# Codec Interrupt Flag and Mask Unit

This unit gathers seven one-cycle event pulses from an audio codec datapath (gain ramp complete in either direction, headphone ramp complete in either direction, short-circuit detected, jack change, short-circuit removed) into a sticky flag register. Software chooses which sources may interrupt through a per-source mask. It acknowledges a flag by writing a one to that flag's bit.

A two-bit form field in a control register shapes the single interrupt output. The output is a level or a one-cycle pulse, and it is active high or active low. The pending state, before the form is applied, is always visible as bit 8 of the read data returned to the register bridge. The bridge reaches the three registers through separate write strobes, separate read strobes and a shared write-data bus.

Top module: `codec_irq_unit`

## Requirements
- R1: After reset the flag register reads 0x00, the mask register reads 0xFF, the control register reads 0x00, and the interrupt output and status bit 8 are 0.
- R2: A one-cycle pulse on evt_i[k] sets flag bit k, and the read value shows it in the cycle after the pulse. The flag stays set until it is cleared. The bit assignment is: 6 short-circuit removed, 5 jack change, 4 short-circuit, 3 headphone ramp-up done, 2 headphone ramp-down done, 1 gain-up done, 0 gain-down done.
- R3: A flag write clears every flag bit whose write-data bit is 1. Bits written with 0 are left unchanged.
- R4: If an event pulse and a clearing write reach the same flag bit in the same cycle, the flag ends up set.
- R5: A mask write stores write-data bits 6:0. Mask bit 7 is not stored and always reads 1.
- R6: The unit is pending when some flag bit is 1 and its mask bit is 0. Read-data bit 8 shows the pending state on every read.
- R7: With form 0 (control bits 7:6 = 00) the output is an active-high level equal to pending. With form 1 (01) it is the inverse of pending.
- R8: With form 2 (10) the output is 1 for exactly the one cycle in which pending rises and 0 otherwise. With form 3 (11) it is the inverse of that pulse.
- R9: A control write stores write-data bits 7:6. Control bits 5:0 always read 0.
- R10: rd_flag_i, rd_mask_i and rd_ctrl_i each select their register onto rdata_o[7:0]. With no read strobe, rdata_o[7:0] is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| evt_i | input | 7 | One-cycle event pulses, one per source |
| wr_flag_i | input | 1 | Write strobe, flag register (write one to clear) |
| wr_mask_i | input | 1 | Write strobe, mask register |
| wr_ctrl_i | input | 1 | Write strobe, control register |
| wdata_i | input | 8 | Write data |
| rd_flag_i | input | 1 | Read select, flag register |
| rd_mask_i | input | 1 | Read select, mask register |
| rd_ctrl_i | input | 1 | Read select, control register |
| rdata_o | output | 9 | Read data; bit 8 is the pending state |
| irq_o | output | 1 | Interrupt output shaped by the form field |

## Verification
A walking single-source event pattern checks that each pulse lands on its own flag bit and nowhere else. Clear writes use mixed patterns of ones and zeros, such as 0x55, to separate clear-on-one from clear-on-zero. An event and a clear aimed at the same bit in the same cycle confirm that the set takes precedence. Masked and unmasked events, together with each of the four form codes, separate the pending state from the shaped output. In particular they show that a pulse form fires only once while pending stays high.

// File: rtl/codec_irq_pkg.sv
// Package: shared constants and the interrupt form encoding.
// Assumes: register data path of 8 bits, form field in the top two bits.
package codec_irq_pkg;
    typedef enum logic [1:0] {
        FORM_LVL_HI = 2'd0,
        FORM_LVL_LO = 2'd1,
        FORM_PLS_HI = 2'd2,
        FORM_PLS_LO = 2'd3
    } irq_form_e;

    localparam int FORM_W = 2;
endpackage

// File: rtl/codec_irq_flags.sv
// Module: sticky event flags with write-one-to-clear.
// Assumes: events are one-cycle pulses; a set in the same cycle as a clear wins.
module codec_irq_flags #(
    parameter int NUM_SRC = 7
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] evt_i,
    input  logic               clr_we_i,
    input  logic [NUM_SRC-1:0] clr_bits_i,
    output logic [NUM_SRC-1:0] flags_o
);
    logic [NUM_SRC-1:0] flags_q;

    for (genvar k = 0; k < NUM_SRC; k++) begin : g_bit
        // Per-source flag: set by event, cleared by a one written to its bit.
        always_ff @(posedge clk) begin
            if (!rst_n)
                flags_q[k] <= 1'b0;
            else if (evt_i[k])
                flags_q[k] <= 1'b1;
            else if (clr_we_i && clr_bits_i[k])
                flags_q[k] <= 1'b0;
        end
    end

    assign flags_o = flags_q;

    // R2: every event pulse leaves its flag set on the next cycle
    p_evt_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (|evt_i) |=> ((flags_q & $past(evt_i)) == $past(evt_i)));

    // R3: a bit written one without a coincident event is clear afterwards
    p_w1c_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
        clr_we_i |=> ((flags_q & $past(clr_bits_i & ~evt_i)) == '0));

    // R2: without a write, set flags remain set
    p_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_we_i |=> ((flags_q & $past(flags_q)) == $past(flags_q)));

    // R4: event and clear on the same bit leave it set
    p_set_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_we_i && |(evt_i & clr_bits_i)) |=>
            ((flags_q & $past(evt_i & clr_bits_i)) == $past(evt_i & clr_bits_i)));
endmodule

// File: rtl/codec_irq_cfg.sv
// Module: mask register and interrupt form control register.
// Assumes: mask resets to all ones (every source masked), form resets to level high.
module codec_irq_cfg #(
    parameter int NUM_SRC = 7,
    parameter int DATA_W  = 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_mask_i,
    input  logic                        wr_ctrl_i,
    input  logic [DATA_W-1:0]           wdata_i,
    output logic [NUM_SRC-1:0]          mask_o,
    output codec_irq_pkg::irq_form_e    form_o
);
    import codec_irq_pkg::*;
    localparam int FORM_LSB = DATA_W - FORM_W;

    logic [NUM_SRC-1:0] mask_q;
    irq_form_e          form_q;

    // Mask register: only the implemented source bits are stored.
    always_ff @(posedge clk) begin
        if (!rst_n)
            mask_q <= '1;
        else if (wr_mask_i)
            mask_q <= wdata_i[NUM_SRC-1:0];
    end

    // Control register: only the form field is stored.
    always_ff @(posedge clk) begin
        if (!rst_n)
            form_q <= FORM_LVL_HI;
        else if (wr_ctrl_i)
            form_q <= irq_form_e'(wdata_i[DATA_W-1:FORM_LSB]);
    end

    assign mask_o = mask_q;
    assign form_o = form_q;

    // R5: a mask write is stored as written
    p_mask_store_r5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_mask_i |=> (mask_q == $past(wdata_i[NUM_SRC-1:0])));

    // R9: without a control write the form holds
    p_form_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_ctrl_i |=> $stable(form_q));
endmodule

// File: rtl/codec_irq_out.sv
// Module: pending detection and output shaping (level or one-cycle pulse, either polarity).
// Assumes: pulse forms fire on the rising edge of pending, tracked by one register.
module codec_irq_out #(
    parameter int NUM_SRC = 7
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NUM_SRC-1:0]       flags_i,
    input  logic [NUM_SRC-1:0]       mask_i,
    input  codec_irq_pkg::irq_form_e form_i,
    output logic                     pending_o,
    output logic                     irq_o
);
    import codec_irq_pkg::*;

    logic pend_q;
    logic pend;
    logic rise;

    // Pending: any unmasked flag.
    always_comb pend = |(flags_i & ~mask_i);

    // Previous pending state for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pend_q <= 1'b0;
        else
            pend_q <= pend;
    end

    // Output former selected by the form field.
    always_comb begin
        rise = pend & ~pend_q;
        unique case (form_i)
            FORM_LVL_HI: irq_o = pend;
            FORM_LVL_LO: irq_o = ~pend;
            FORM_PLS_HI: irq_o = rise;
            FORM_PLS_LO: irq_o = ~rise;
            default:     irq_o = pend;
        endcase
    end

    assign pending_o = pend;

    // R8: a high pulse lasts a single cycle while the form stays at 2
    p_pulse_hi_one_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (form_i == FORM_PLS_HI && irq_o) |=> (form_i != FORM_PLS_HI || !irq_o));

    // R8: a low pulse lasts a single cycle while the form stays at 3
    p_pulse_lo_one_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (form_i == FORM_PLS_LO && !irq_o) |=> (form_i != FORM_PLS_LO || irq_o));
endmodule

// File: rtl/codec_irq_unit.sv
// Module: top of the codec interrupt flag and mask unit.
// Assumes: read strobes are one-hot when used; flag read has priority otherwise.
module codec_irq_unit #(
    parameter int NUM_SRC = 7,
    parameter int DATA_W  = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] evt_i,
    input  logic               wr_flag_i,
    input  logic               wr_mask_i,
    input  logic               wr_ctrl_i,
    input  logic [DATA_W-1:0]  wdata_i,
    input  logic               rd_flag_i,
    input  logic               rd_mask_i,
    input  logic               rd_ctrl_i,
    output logic [DATA_W:0]    rdata_o,
    output logic               irq_o
);
    import codec_irq_pkg::*;
    localparam int PAD_W    = DATA_W - NUM_SRC;
    localparam int FORM_LSB = DATA_W - FORM_W;

    logic [NUM_SRC-1:0] flags;
    logic [NUM_SRC-1:0] mask;
    irq_form_e          form;
    logic               pending;

    codec_irq_flags #(.NUM_SRC(NUM_SRC)) u_flags (
        .clk        (clk),
        .rst_n      (rst_n),
        .evt_i      (evt_i),
        .clr_we_i   (wr_flag_i),
        .clr_bits_i (wdata_i[NUM_SRC-1:0]),
        .flags_o    (flags)
    );

    codec_irq_cfg #(.NUM_SRC(NUM_SRC), .DATA_W(DATA_W)) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_mask_i (wr_mask_i),
        .wr_ctrl_i (wr_ctrl_i),
        .wdata_i   (wdata_i),
        .mask_o    (mask),
        .form_o    (form)
    );

    codec_irq_out #(.NUM_SRC(NUM_SRC)) u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .flags_i   (flags),
        .mask_i    (mask),
        .form_i    (form),
        .pending_o (pending),
        .irq_o     (irq_o)
    );

    // Read mux: selected register in the low byte, pending state on top.
    always_comb begin
        rdata_o = '0;
        if (rd_flag_i)
            rdata_o[DATA_W-1:0] = {{PAD_W{1'b0}}, flags};
        else if (rd_mask_i)
            rdata_o[DATA_W-1:0] = {{PAD_W{1'b1}}, mask};
        else if (rd_ctrl_i)
            rdata_o[DATA_W-1:FORM_LSB] = form;
        rdata_o[DATA_W] = pending;
    end

    // R7: level-high form follows unmasked flags from separate registers
    p_level_hi_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (form == FORM_LVL_HI) |-> (irq_o == |(flags & ~mask)));

    // R6: a fully masked flag set never shows as pending
    p_masked_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (&mask) |-> !rdata_o[DATA_W]);
endmodule

// File: tb/codec_irq_unit_tb_top.sv
module codec_irq_unit_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [6:0] evt = '0;
    logic       wrf = 0, wrm = 0, wrc = 0;
    logic [7:0] wd = '0;
    logic       rdf = 0, rdm = 0, rdc = 0;
    logic [8:0] rdata;
    logic       irq;

    int tests = 0;
    int fails = 0;
    bit done = 0;

    // reference model state
    int m_flag = 0, m_mask = 'h7F, m_form = 0, m_prev = 0;

    always #10 clk = ~clk;

    codec_irq_unit dut_i (
        .clk(clk), .rst_n(rst_n), .evt_i(evt),
        .wr_flag_i(wrf), .wr_mask_i(wrm), .wr_ctrl_i(wrc), .wdata_i(wd),
        .rd_flag_i(rdf), .rd_mask_i(rdm), .rd_ctrl_i(rdc),
        .rdata_o(rdata), .irq_o(irq)
    );

    function automatic int m_pend();
        return ((m_flag & ~m_mask & 'h7F) != 0) ? 1 : 0;
    endfunction

    function automatic int m_irq();
        int p = m_pend();
        int r = (p != 0 && m_prev == 0) ? 1 : 0;
        case (m_form)
            0: return p;
            1: return 1 - p;
            2: return r;
            default: return 1 - r;
        endcase
    endfunction

    function automatic int m_rdata();
        int v = 0;
        if (rdf) v = m_flag;
        else if (rdm) v = m_mask | 'h80;
        else if (rdc) v = m_form << 6;
        return v | (m_pend() << 8);
    endfunction

    task automatic check(string tag);
        tests++;
        if (irq !== m_irq()[0]) begin
            fails++;
            $display("FAIL %s irq act=%0b exp=%0b", tag, irq, m_irq());
        end
        tests++;
        if (rdata !== m_rdata()[8:0]) begin
            fails++;
            $display("FAIL %s rdata act=%03h exp=%03h", tag, rdata, m_rdata());
        end
    endtask

    // one cycle: drive, model the edge, compare at falling edge
    task automatic step(string tag, logic [6:0] e, logic f, logic m, logic c,
                        logic [7:0] d, int rsel);
        evt = e; wrf = f; wrm = m; wrc = c; wd = d;
        rdf = (rsel == 1); rdm = (rsel == 2); rdc = (rsel == 3);
        @(posedge clk);
        m_prev = m_pend();
        if (f) m_flag = m_flag & ~int'(d[6:0]);
        m_flag = m_flag | int'(e);
        if (m) m_mask = int'(d[6:0]);
        if (c) m_form = int'(d[7:6]);
        @(negedge clk);
        evt = '0; wrf = 0; wrm = 0; wrc = 0;
        check(tag);
    endtask

    task automatic idle(string tag, int rsel);
        step(tag, 7'h00, 0, 0, 0, 8'h00, rsel);
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            fails++; tests++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset values
        idle("R1 flags", 1);
        idle("R1 mask", 2);
        idle("R1 ctrl", 3);
        // R6 masked event is not pending; R2 flag still sets
        step("R6 masked evt", 7'h01, 0, 0, 0, 8'h00, 1);
        // R5 unmask all, bit 7 reads one
        step("R5 mask write", 7'h00, 0, 1, 0, 8'h80, 2);
        step("R3 clear all", 7'h00, 1, 0, 0, 8'h7F, 1);
        // R2 walking events
        for (int k = 0; k < 7; k++) begin
            step("R2 walk evt", 7'(1 << k), 0, 0, 0, 8'h00, 1);
            step("R3 walk clr", 7'h00, 1, 0, 0, 8'(1 << k), 1);
        end
        // R3 zeros have no effect, ones clear
        step("R2 set all", 7'h7F, 0, 0, 0, 8'h00, 1);
        step("R3 write zero", 7'h00, 1, 0, 0, 8'h00, 1);
        step("R3 clear 55", 7'h00, 1, 0, 0, 8'h55, 1);
        idle("R7 level hi", 1);
        step("R3 clear rest", 7'h00, 1, 0, 0, 8'h7F, 1);
        // R4 set wins over clear
        step("R4 set", 7'h08, 1, 0, 0, 8'h08, 1);
        step("R4 mixed", 7'h08, 1, 0, 0, 8'h0C, 1);
        step("R3 clr", 7'h00, 1, 0, 0, 8'h7F, 1);
        // R6 per-source mask
        step("R6 mask b5", 7'h00, 0, 1, 0, 8'h20, 2);
        step("R6 evt b5", 7'h20, 0, 0, 0, 8'h00, 1);
        step("R6 unmask", 7'h00, 0, 1, 0, 8'h00, 2);
        step("R6 evt b0", 7'h01, 0, 0, 0, 8'h00, 1);
        // R7 active-low level, R9 control read
        step("R7 form1", 7'h00, 0, 0, 1, 8'h7F, 3);
        step("R7 low clr", 7'h00, 1, 0, 0, 8'h7F, 3);
        step("R7 low set", 7'h40, 0, 0, 0, 8'h00, 3);
        // R8 high pulse
        step("R8 form2", 7'h00, 0, 0, 1, 8'h80, 3);
        step("R8 clr", 7'h00, 1, 0, 0, 8'h7F, 1);
        step("R8 rise", 7'h02, 0, 0, 0, 8'h00, 1);
        idle("R8 after", 1);
        step("R8 second evt", 7'h04, 0, 0, 0, 8'h00, 1);
        // R8 low pulse
        step("R8 form3", 7'h00, 0, 0, 1, 8'hFF, 3);
        step("R8 lo clr", 7'h00, 1, 0, 0, 8'h7F, 1);
        step("R8 lo rise", 7'h10, 0, 0, 0, 8'h00, 1);
        idle("R8 lo after", 1);
        // R8 pulse on unmask edge
        step("R8 mask all", 7'h00, 0, 1, 0, 8'h7F, 2);
        step("R8 unmask rise", 7'h00, 0, 1, 0, 8'h00, 2);
        // R10 no strobe
        idle("R10 no read", 0);
        step("R9 form0", 7'h00, 0, 0, 1, 8'h3F, 3);
        idle("R10 no read 2", 0);
        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule